// File: doc/BRIEF.md
# Low-Power Real-Time Counter with Seconds Alarm

This peripheral keeps wall-clock time in a 47-bit counter that advances on every edge of a 32.768 kHz slow clock. The upper 32 bits of the counter are whole seconds and the lowest 15 bits are sub-second ticks. A 32-bit register bus, clocked by the system clock, reaches the control word, the sticky status flag, the two counter words, the alarm time and a general-purpose scratch word.

Software sets the time by first disabling the counter and then writing the two counter words. The counter follows those words while it is stopped and starts counting from them once it is enabled again. The enable bits travel from the bus domain into the slow domain through synchronisers. A control read returns the enables that are actually active in the slow domain, so software polls the control word until it shows the value it wrote.

The alarm compares the whole-second value against the alarm register. A match sets a status flag that holds until software clears it. The flag, gated by the effective interrupt enable, drives an interrupt/wakeup line.

Top module: `rtc_lp_alarm`

## Requirements
- R1: After reset every mapped register reads zero and irqOut is low.
- R2: Registers are at byte offsets 0x04 control, 0x18 status, 0x1C counter high, 0x20 counter low, 0x24 alarm and 0x30 scratch. Any other offset reads zero, and writes to it change nothing.
- R3: Control bit 0 enables counting, bit 1 enables the alarm and bit 3 enables the interrupt. A control read returns those bits only once the slow domain has taken them up, so the read straight after a write still shows the old value. All other control bits read zero.
- R4: While counting is disabled, a write to counter low sets counter bits 31:0, and a write to counter high sets counter bits 46:32 from its data bits 14:0. Both words read back the loaded value.
- R5: While enabled, the counter advances by one on each slow-clock edge. The seconds value is the counter shifted right by 15.
- R6: Writes to either counter word are ignored while counting is enabled or its enable is still pending.
- R7: While the alarm is enabled and the seconds value equals the alarm register, status bit 0 becomes 1.
- R8: Status bit 0 stays set until a bus write with data bit 0 equal to 1 clears it. Writing 0 to it has no effect.
- R9: irqOut is high exactly when status bit 0 is set and the effective interrupt enable (control bit 3) is on.
- R10: With the alarm disabled, the seconds value reaching the alarm value does not set the status flag.
- R11: The scratch word is 32-bit read/write storage that resets to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| slowClk | input | 1 | 32.768 kHz counting clock |
| busAddr | input | 6 | Byte address of the register access |
| busWr | input | 1 | Write strobe, one bus cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irqOut | output | 1 | Alarm interrupt / wakeup request |

## Verification
The hardest state to reach is a live alarm match, because the seconds value changes only once every 32768 slow ticks. The bench loads the counter just sixteen ticks before a whole-second boundary while it is stopped, sets the alarm to the next second and then enables counting. The match then occurs within a few hundred bus cycles and holds for the rest of the run. Because the match persists, the clear and interrupt-gating checks are made only after the alarm enable has been withdrawn and its removal has been seen in the control readback.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [5:0] OFS_CTRL    = 6'h04;
  localparam logic [5:0] OFS_STAT    = 6'h18;
  localparam logic [5:0] OFS_CNTHI   = 6'h1C;
  localparam logic [5:0] OFS_CNTLO   = 6'h20;
  localparam logic [5:0] OFS_ALARM   = 6'h24;
  localparam logic [5:0] OFS_SCRATCH = 6'h30;

  typedef struct packed {
    logic irqEn;
    logic alarmEn;
    logic cntEn;
  } rtcEn_t;

  typedef struct packed {
    logic        wrCntLo;
    logic        wrCntHi;
    logic        wrAlarm;
    logic        wrScratch;
    logic [31:0] data;
  } rtcStrobe_t;
endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[gi] <= '0;
        else if (gi == 0) stage[gi] <= d;
        else stage[gi] <= stage[(gi == 0) ? 0 : gi - 1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int unsigned SUB_BITS = 15,
  parameter int unsigned SEC_BITS = 32,
  localparam int unsigned CNT_W   = SUB_BITS + SEC_BITS,
  localparam int unsigned HI_W    = CNT_W - 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slowClk,
  input  rtcStrobe_t          strb,
  input  rtcEn_t              enReq,
  output rtcEn_t              enAck,
  output logic                matchBus,
  output logic [HI_W-1:0]     snapHi,
  output logic [31:0]         snapLo,
  output logic [SEC_BITS-1:0] alarmVal,
  output logic [31:0]         scratchVal
);
  // bus-domain storage
  logic [31:0]       loadLo;
  logic [HI_W-1:0]   loadHi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loadLo     <= '0;
      loadHi     <= '0;
      alarmVal   <= '0;
      scratchVal <= '0;
    end else begin
      if (strb.wrCntLo)   loadLo     <= strb.data;
      if (strb.wrCntHi)   loadHi     <= strb.data[HI_W-1:0];
      if (strb.wrAlarm)   alarmVal   <= strb.data[SEC_BITS-1:0];
      if (strb.wrScratch) scratchVal <= strb.data;
    end
  end

  // slow-domain enables
  logic [2:0] enSlowBits;
  rtcEn_t     enSlow;
  rtc_sync #(.W(3), .STAGES(2)) u_enIn (
    .clk(slowClk), .rst_n(rst_n), .d(enReq), .q(enSlowBits)
  );
  assign enSlow = rtcEn_t'(enSlowBits);

  // counter and seconds compare
  logic [CNT_W-1:0]    counter;
  logic [SEC_BITS-1:0] seconds;
  logic                matchSlow;

  assign seconds = counter[CNT_W-1:SUB_BITS];

  always_ff @(posedge slowClk or negedge rst_n) begin
    if (!rst_n) begin
      counter   <= '0;
      matchSlow <= 1'b0;
    end else begin
      if (!enSlow.cntEn) counter <= {loadHi, loadLo};
      else               counter <= counter + 1'b1;
      matchSlow <= enSlow.alarmEn && (seconds == alarmVal);
    end
  end

  // back into the bus domain
  logic [2:0]       enAckBits;
  logic [CNT_W-1:0] cntSnap;

  rtc_sync #(.W(3), .STAGES(2)) u_enBack (
    .clk(clk), .rst_n(rst_n), .d(enSlow), .q(enAckBits)
  );
  rtc_sync #(.W(1), .STAGES(2)) u_matchBack (
    .clk(clk), .rst_n(rst_n), .d(matchSlow), .q(matchBus)
  );
  rtc_sync #(.W(CNT_W), .STAGES(2)) u_cntBack (
    .clk(clk), .rst_n(rst_n), .d(counter), .q(cntSnap)
  );

  assign enAck  = rtcEn_t'(enAckBits);
  assign snapHi = cntSnap[CNT_W-1:32];
  assign snapLo = cntSnap[31:0];

  // R5: one step per slow edge while counting stays enabled
  a_r5_count_step: assert property (@(posedge slowClk) disable iff (!rst_n)
    enSlow.cntEn |=> (!enSlow.cntEn || counter == $past(counter) + 1'b1));

  // R10: a match can only come from an enabled alarm
  a_r10_match_gated: assert property (@(posedge slowClk) disable iff (!rst_n)
    matchSlow |-> $past(enSlow.alarmEn));

  // R6: counter words only load while the slow domain reports counting off
  a_r6_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrCntLo || strb.wrCntHi) |-> !enAck.cntEn);
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned SEC_BITS = 32,
  parameter int unsigned HI_W     = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                irqOut,
  output rtcStrobe_t          strb,
  output rtcEn_t              enReq,
  input  rtcEn_t              enAck,
  input  logic                matchBus,
  input  logic [HI_W-1:0]     snapHi,
  input  logic [31:0]         snapLo,
  input  logic [SEC_BITS-1:0] alarmVal,
  input  logic [31:0]         scratchVal
);
  logic selCtrl, selStat, selHi, selLo, selAlarm, selScratch;
  assign selCtrl    = busAddr == ADDR_W'(OFS_CTRL);
  assign selStat    = busAddr == ADDR_W'(OFS_STAT);
  assign selHi      = busAddr == ADDR_W'(OFS_CNTHI);
  assign selLo      = busAddr == ADDR_W'(OFS_CNTLO);
  assign selAlarm   = busAddr == ADDR_W'(OFS_ALARM);
  assign selScratch = busAddr == ADDR_W'(OFS_SCRATCH);

  logic cntBusy;
  assign cntBusy = enReq.cntEn || enAck.cntEn;

  always_comb begin
    strb.data      = busWdata;
    strb.wrCntLo   = busWr && selLo && !cntBusy;
    strb.wrCntHi   = busWr && selHi && !cntBusy;
    strb.wrAlarm   = busWr && selAlarm;
    strb.wrScratch = busWr && selScratch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enReq <= '0;
    else if (busWr && selCtrl)
      enReq <= '{irqEn: busWdata[3], alarmEn: busWdata[1], cntEn: busWdata[0]};
  end

  logic alarmFlag, statClr;
  assign statClr = busWr && selStat && busWdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarmFlag <= 1'b0;
    else        alarmFlag <= matchBus || (alarmFlag && !statClr);
  end

  assign irqOut = alarmFlag && enAck.irqEn;

  always_comb begin
    busRdata = '0;
    unique case (1'b1)
      selCtrl:    busRdata = {28'd0, enAck.irqEn, 1'b0, enAck.alarmEn, enAck.cntEn};
      selStat:    busRdata = {31'd0, alarmFlag};
      selHi:      busRdata = 32'(snapHi);
      selLo:      busRdata = snapLo;
      selAlarm:   busRdata = 32'(alarmVal);
      selScratch: busRdata = scratchVal;
      default:    busRdata = '0;
    endcase
  end

  // R7: a synchronised match always leaves the flag set
  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    matchBus |=> alarmFlag);

  // R8: flag holds unless cleared
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alarmFlag && !statClr) |=> alarmFlag);

  // R8: clear with no match pending drops the flag
  a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (statClr && !matchBus) |=> !alarmFlag);
endmodule

// File: rtl/rtc_lp_alarm.sv
module rtc_lp_alarm
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned SUB_BITS = 15,
  parameter int unsigned SEC_BITS = 32,
  localparam int unsigned HI_W    = SUB_BITS + SEC_BITS - 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slowClk,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqOut
);
  rtcStrobe_t          strb;
  rtcEn_t              enReq, enAck;
  logic                matchBus;
  logic [HI_W-1:0]     snapHi;
  logic [31:0]         snapLo;
  logic [SEC_BITS-1:0] alarmVal;
  logic [31:0]         scratchVal;

  rtc_regs #(.ADDR_W(ADDR_W), .SEC_BITS(SEC_BITS), .HI_W(HI_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
    .strb(strb), .enReq(enReq), .enAck(enAck), .matchBus(matchBus),
    .snapHi(snapHi), .snapLo(snapLo), .alarmVal(alarmVal),
    .scratchVal(scratchVal)
  );

  rtc_datapath #(.SUB_BITS(SUB_BITS), .SEC_BITS(SEC_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n), .slowClk(slowClk), .strb(strb),
    .enReq(enReq), .enAck(enAck), .matchBus(matchBus),
    .snapHi(snapHi), .snapLo(snapLo), .alarmVal(alarmVal),
    .scratchVal(scratchVal)
  );
endmodule

// File: tb/rtc_lp_alarm_tb_top.sv
module rtc_lp_alarm_tb_top;
  logic        clk = 1'b0;
  logic        slowClk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;       // 50 MHz bus clock
  always #31 slowClk = ~slowClk; // fast stand-in for the slow clock

  rtc_lp_alarm dut_i (
    .clk(clk), .rst_n(rst_n), .slowClk(slowClk), .busAddr(busAddr),
    .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  localparam int NV = 9;
  localparam logic [5:0]  V_ADDR [NV] = '{6'h30, 6'h30, 6'h24, 6'h20, 6'h1C,
                                          6'h04, 6'h04, 6'h08, 6'h18};
  localparam logic [31:0] V_WR   [NV] = '{32'h41736166, 32'h0, 32'h12345678,
                                          32'hDEADBEEF, 32'hFFFFABCD, 32'h000000F6,
                                          32'h0, 32'hFFFFFFFF, 32'h0};
  localparam logic [31:0] V_EXP  [NV] = '{32'h41736166, 32'h0, 32'h12345678,
                                          32'hDEADBEEF, 32'h00002BCD, 32'h00000002,
                                          32'h0, 32'h0, 32'h0};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readStable(input logic [5:0] a, output logic [31:0] d);
    logic [31:0] x, y;
    d = '0;
    for (int k = 0; k < 20; k++) begin
      busRead(a, x);
      idle(4);
      busRead(a, y);
      if (y >= x && (y - x) <= 32'd8) begin
        d = y;
        break;
      end
    end
  endtask

  initial begin
    logic [31:0] rd, t1, t2;
    idle(5);
    rst_n = 1'b1;
    idle(3);

    // R1: reset state
    busRead(6'h04, rd); check("R1 ctrl", rd, 0);
    busRead(6'h18, rd); check("R1 status", rd, 0);
    busRead(6'h1C, rd); check("R1 cnt hi", rd, 0);
    busRead(6'h20, rd); check("R1 cnt lo", rd, 0);
    busRead(6'h24, rd); check("R1 alarm", rd, 0);
    busRead(6'h30, rd); check("R1 scratch", rd, 0);
    check("R1 irq", {31'd0, irqOut}, 0);

    // vector table: R11 scratch, R2 map, R4 load, R3 ctrl bits
    for (int i = 0; i < NV; i++) begin
      busWrite(V_ADDR[i], V_WR[i]);
      idle(40);
      busRead(V_ADDR[i], rd);
      check($sformatf("R2/R3/R4/R11 vector %0d", i), rd, V_EXP[i]);
    end

    // load 16 ticks before second 6, alarm at 6 but alarm disabled
    busWrite(6'h1C, 32'h0);
    busWrite(6'h20, 32'h0002FFF0);
    busWrite(6'h24, 32'd6);
    idle(40);
    busRead(6'h20, rd); check("R4 lo loaded", rd, 32'h0002FFF0);

    // R3: enable reads back late
    busWrite(6'h04, 32'h1);
    busRead(6'h04, rd); check("R3 ctrl not yet taken", rd, 0);
    idle(40);
    busRead(6'h04, rd); check("R3 ctrl taken", rd, 32'h1);

    // R5: counting rate and seconds
    readStable(6'h20, t1);
    idle(1000);
    readStable(6'h20, t2);
    nChecks++;
    if (!((t2 - t1) >= 32'd280 && (t2 - t1) <= 32'd380)) begin
      nFails++;
      $display("FAIL R5 tick delta actual=%0d expected=280..380", t2 - t1);
    end
    check("R5 seconds", t2 >> 15, 32'd6);

    // R10: alarm disabled, seconds equals alarm, no flag
    busRead(6'h18, rd); check("R10 no flag", rd, 0);
    check("R10 no irq", {31'd0, irqOut}, 0);

    // R6: counter writes ignored while enabled
    busWrite(6'h20, 32'h0);
    busWrite(6'h1C, 32'h7FFF);
    idle(40);
    readStable(6'h20, rd);
    nChecks++;
    if (rd <= t2) begin
      nFails++;
      $display("FAIL R6 lo after write actual=0x%08h expected=>0x%08h", rd, t2);
    end
    busRead(6'h1C, rd); check("R6 hi unchanged", rd, 0);

    // disable and reload, then run with alarm on, irq off
    busWrite(6'h04, 32'h0);
    idle(40);
    busRead(6'h04, rd); check("R3 ctrl off", rd, 0);
    busWrite(6'h20, 32'h0002FFF0);
    idle(40);
    busWrite(6'h04, 32'h3);
    idle(200);
    busRead(6'h18, rd); check("R7 flag set", rd, 32'h1);
    check("R9 irq off without enable", {31'd0, irqOut}, 0);

    // R8: writing zero does not clear
    busWrite(6'h18, 32'h0);
    busRead(6'h18, rd); check("R8 write zero keeps flag", rd, 32'h1);

    // alarm off, interrupt on
    busWrite(6'h04, 32'h9);
    idle(40);
    busRead(6'h04, rd); check("R3 ctrl irq+cnt", rd, 32'h9);
    busRead(6'h18, rd); check("R8 flag held after match ends", rd, 32'h1);
    check("R9 irq asserted", {31'd0, irqOut}, 32'h1);

    busWrite(6'h18, 32'h1);
    busRead(6'h18, rd); check("R8 flag cleared", rd, 0);
    check("R9 irq dropped", {31'd0, irqOut}, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule